// File: doc/BRIEF.md
# Descriptor Ring Poll Scheduler

This block decides when the DMA engine of a network controller should fetch the receive or the transmit descriptor from the host-memory rings. A poll interval counter sets the pace. It advances only while no other controller operation is in progress. When it stops it holds its value; it does not restart from zero. When the count reaches the programmed interval, the block raises an elapsed indication for each ring. The block then checks the enable flags and the ownership flags to decide whether a fetch is needed.

Other events force a poll without waiting for the interval. These are a received packet, a transmitted packet and a software transmit demand. Each ring has one request line. Each request is a single-cycle pulse, and at most one request per ring waits for acknowledgement at any time. When both rings have work, the receive request always goes out before the transmit request.

Top module: `poll_sched`

## Requirements
- R1: During and after reset no poll pulse is driven, and the interval register holds 32768.
- R2: Assume busy_i is low and the counter starts at zero. The elapsed indication is set at the edge that completes the interval-th advancing cycle. The poll pulse is visible in the cycle after the next edge. Later elapsed indications follow every interval advancing cycles.
- R3: The counter does not advance while busy_i is high, and it keeps its value. It continues from that value when busy_i falls. No poll is issued while busy_i is high.
- R4: A receive poll is needed when rx_en_i is high and either the current receive descriptor is not owned, or the next one is not owned and rx_ring_one_i is low. When rx_ring_one_i is high, the next descriptor is never considered.
- R5: While rx_en_i is low, no receive poll is issued.
- R6: A transmit poll needs all three of the following: tx_cur_own_i low, tx_poll_dis_i low and tx_en_i high. Otherwise no transmit poll is issued.
- R7: A pulse on rx_done_i or tx_done_i forces a poll of each ring that needs one. The poll does not wait for the interval.
- R8: A pulse on tx_demand_i forces an immediate poll. A receive poll that is pending or outstanding always goes out before the transmit poll, so the two pulses never coincide.
- R9: Each poll output is a one-cycle pulse. After a pulse, that ring issues no further request until its ack input has been sampled high.
- R10: A write to the interval register takes effect only when cfg_win_i is high in the same cycle. Outside that window the write is ignored.
- R11: An elapsed or forced trigger stays pending while it is blocked by busy_i, by priority or by an outstanding request. The poll is issued once the block is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enabled |
| tx_en_i | input | 1 | Transmit enabled |
| tx_poll_dis_i | input | 1 | Transmit interval polling disabled |
| rx_cur_own_i | input | 1 | Controller owns the current receive descriptor |
| rx_nxt_own_i | input | 1 | Controller owns the next receive descriptor |
| rx_ring_one_i | input | 1 | Receive ring has one entry |
| tx_cur_own_i | input | 1 | Controller owns the current transmit descriptor |
| busy_i | input | 1 | Another controller operation is running |
| rx_done_i | input | 1 | Packet-received pulse |
| tx_done_i | input | 1 | Packet-transmitted pulse |
| tx_demand_i | input | 1 | Software transmit demand strobe |
| cfg_we_i | input | 1 | Interval register write |
| cfg_win_i | input | 1 | Initialized-but-not-started window |
| cfg_ivl_i | input | CNT_W | Interval value to write |
| rx_ack_i | input | 1 | Fetch engine accepted the receive poll |
| tx_ack_i | input | 1 | Fetch engine accepted the transmit poll |
| rx_poll_o | output | 1 | Receive descriptor poll pulse |
| tx_poll_o | output | 1 | Transmit descriptor poll pulse |

## Verification
The hardest case to reach is a trigger that stays latched behind an outstanding request. The bench holds the receive acknowledge low while two full intervals elapse and checks that no second pulse appears. It then gives a single manual acknowledge and expects the latched poll two cycles later. Pause-and-resume timing is reached by raising busy_i in the middle of an interval. The expected edge count is computed with the frozen cycles excluded.

// File: rtl/poll_sched_pkg.sv
package poll_sched_pkg;
  localparam int NUM_RINGS = 2;
  localparam int RING_RX   = 0;
  localparam int RING_TX   = 1;

  typedef struct packed {
    logic rx_en;
    logic tx_en;
    logic tx_poll_dis;
    logic rx_cur_own;
    logic rx_nxt_own;
    logic rx_ring_one;
    logic tx_cur_own;
  } ring_state_t;

  function automatic logic rx_needs_poll(ring_state_t s);
    return s.rx_en & (~s.rx_cur_own | (~s.rx_ring_one & ~s.rx_nxt_own));
  endfunction

  function automatic logic tx_needs_poll(ring_state_t s);
    return s.tx_en & ~s.tx_poll_dis & ~s.tx_cur_own;
  endfunction
endpackage

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int CNT_W   = 16,
  parameter int DEF_IVL = 32768
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cfg_we_i,
  input  logic             cfg_win_i,
  input  logic [CNT_W-1:0] cfg_ivl_i,
  output logic             tick_o
);
  localparam logic [CNT_W-1:0] IVL_RST = CNT_W'(DEF_IVL);

  logic [CNT_W-1:0] ivl_q, cnt_q;
  logic [CNT_W:0]   cnt_nx;

  assign cnt_nx = {1'b0, cnt_q} + 1'b1;
  // Zero interval behaves as one
  assign tick_o = run_i & (cnt_nx >= {1'b0, ivl_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ivl_q <= IVL_RST;
      cnt_q <= '0;
    end else begin
      if (cfg_we_i && cfg_win_i) ivl_q <= cfg_ivl_i;
      if (run_i) cnt_q <= tick_o ? '0 : cnt_nx[CNT_W-1:0];
    end
  end

  p_hold_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q));
  p_cfg_window_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_we_i && cfg_win_i) |=> $stable(ivl_q));
endmodule

// File: rtl/poll_ring_ctl.sv
module poll_ring_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic need_i,
  input  logic hold_i,
  input  logic ack_i,
  output logic poll_o,
  output logic pend_o,
  output logic out_o
);
  logic pend_q, out_q, poll_q, issue;

  assign issue = pend_q & need_i & ~out_q & ~hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      out_q  <= 1'b0;
      poll_q <= 1'b0;
    end else begin
      // New trigger in the issue cycle survives for a later poll
      pend_q <= ((pend_q & ~issue) | trig_i) & need_i;
      out_q  <= issue | (out_q & ~ack_i);
      poll_q <= issue;
    end
  end

  assign poll_o = poll_q;
  assign pend_o = pend_q;
  assign out_o  = out_q;

  p_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_o |=> !poll_o);
endmodule

// File: rtl/poll_sched.sv
module poll_sched
  import poll_sched_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DEF_IVL = 32768
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_en_i,
  input  logic             tx_en_i,
  input  logic             tx_poll_dis_i,
  input  logic             rx_cur_own_i,
  input  logic             rx_nxt_own_i,
  input  logic             rx_ring_one_i,
  input  logic             tx_cur_own_i,
  input  logic             busy_i,
  input  logic             rx_done_i,
  input  logic             tx_done_i,
  input  logic             tx_demand_i,
  input  logic             cfg_we_i,
  input  logic             cfg_win_i,
  input  logic [CNT_W-1:0] cfg_ivl_i,
  input  logic             rx_ack_i,
  input  logic             tx_ack_i,
  output logic             rx_poll_o,
  output logic             tx_poll_o
);
  ring_state_t st;
  logic tick, force_poll;
  logic [NUM_RINGS-1:0] need, trig, hold, ack, poll, pend, outs;

  assign st = '{rx_en: rx_en_i, tx_en: tx_en_i, tx_poll_dis: tx_poll_dis_i,
                rx_cur_own: rx_cur_own_i, rx_nxt_own: rx_nxt_own_i,
                rx_ring_one: rx_ring_one_i, tx_cur_own: tx_cur_own_i};

  poll_timer #(.CNT_W(CNT_W), .DEF_IVL(DEF_IVL)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (~busy_i),
    .cfg_we_i  (cfg_we_i),
    .cfg_win_i (cfg_win_i),
    .cfg_ivl_i (cfg_ivl_i),
    .tick_o    (tick)
  );

  assign force_poll = rx_done_i | tx_done_i | tx_demand_i;

  assign need[RING_RX] = rx_needs_poll(st);
  assign need[RING_TX] = tx_needs_poll(st);
  assign ack[RING_RX]  = rx_ack_i;
  assign ack[RING_TX]  = tx_ack_i;
  assign hold[RING_RX] = busy_i;
  // Receive work in flight keeps the transmit poll back
  assign hold[RING_TX] = busy_i | (pend[RING_RX] & need[RING_RX]) | outs[RING_RX];

  for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
    assign trig[g] = tick | force_poll;

    poll_ring_ctl u_ctl (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .trig_i (trig[g]),
      .need_i (need[g]),
      .hold_i (hold[g]),
      .ack_i  (ack[g]),
      .poll_o (poll[g]),
      .pend_o (pend[g]),
      .out_o  (outs[g])
    );

    p_one_outstanding_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (outs[g] && !ack[g]) |=> !poll[g]);
    p_latched_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend[g] && need[g] && hold[g]) |=> pend[g]);
  end

  assign rx_poll_o = poll[RING_RX];
  assign tx_poll_o = poll[RING_TX];

  p_rx_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !rx_poll_o);
  p_ring_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_cur_own_i && rx_ring_one_i) |=> !rx_poll_o);
  p_tx_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_poll_dis_i || !tx_en_i || tx_cur_own_i) |=> !tx_poll_o);
  p_busy_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !(rx_poll_o || tx_poll_o));
  p_order_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_poll_o, tx_poll_o}));
endmodule

// File: tb/test_poll_sched.sv
module test_poll_sched;
  localparam int CNT_W = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_en_i, tx_en_i, tx_poll_dis_i, rx_cur_own_i, rx_nxt_own_i, rx_ring_one_i;
  logic tx_cur_own_i, busy_i, rx_done_i, tx_done_i, tx_demand_i;
  logic cfg_we_i, cfg_win_i;
  logic [CNT_W-1:0] cfg_ivl_i;
  logic rx_ack_i, tx_ack_i, rx_poll_o, tx_poll_o;
  logic ack_auto, rx_ack_man;

  int checks = 0, fails = 0;
  int rx_n, tx_n, rx_first, tx_first, both_n;

  always #2 clk_i = ~clk_i;

  assign rx_ack_i = ack_auto ? rx_poll_o : rx_ack_man;
  assign tx_ack_i = tx_poll_o;

  poll_sched #(.CNT_W(CNT_W), .DEF_IVL(32768)) i_poll_sched (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Observe n negedges; strobes set before the call last exactly one edge
  task automatic watch(input int n);
    rx_n = 0; tx_n = 0; rx_first = 0; tx_first = 0; both_n = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk_i);
      rx_done_i = 0; tx_done_i = 0; tx_demand_i = 0; rx_ack_man = 0;
      if (rx_poll_o) begin rx_n++; if (rx_first == 0) rx_first = i; end
      if (tx_poll_o) begin tx_n++; if (tx_first == 0) tx_first = i; end
      if (rx_poll_o && tx_poll_o) both_n++;
    end
  endtask

  // Leaves busy_i high so the counter stays at zero
  task automatic do_reset(input bit prog, input bit win, input int ivl);
    rst_ni = 0; busy_i = 1; ack_auto = 1; rx_ack_man = 0;
    rx_en_i = 0; tx_en_i = 0; tx_poll_dis_i = 0; rx_cur_own_i = 1; rx_nxt_own_i = 1;
    rx_ring_one_i = 0; tx_cur_own_i = 1; rx_done_i = 0; tx_done_i = 0; tx_demand_i = 0;
    cfg_we_i = 0; cfg_win_i = 0; cfg_ivl_i = '0;
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    if (prog) begin
      cfg_we_i = 1; cfg_win_i = win; cfg_ivl_i = CNT_W'(ivl);
      @(negedge clk_i);
      cfg_we_i = 0; cfg_win_i = 0;
    end
  endtask

  task automatic t_reset_default;
    do_reset(1'b0, 1'b0, 0);
    rst_ni = 0;
    @(negedge clk_i);
    chk("R1 rx low in reset", int'(rx_poll_o), 0);
    chk("R1 tx low in reset", int'(tx_poll_o), 0);
    do_reset(1'b1, 1'b0, 20);
    rx_en_i = 1; rx_cur_own_i = 0;
    busy_i = 0;
    watch(33000);
    chk("R1 default interval", rx_first, 32769);
    chk("R10 write outside window ignored", rx_n, 1);
  endtask

  task automatic t_interval;
    do_reset(1'b1, 1'b1, 20);
    rx_en_i = 1; rx_cur_own_i = 0;
    busy_i = 0;
    watch(45);
    chk("R2 R10 first poll", rx_first, 21);
    chk("R2 periodic count", rx_n, 2);
  endtask

  task automatic t_pause;
    do_reset(1'b1, 1'b1, 20);
    rx_en_i = 1; rx_cur_own_i = 0;
    busy_i = 0;
    watch(5);
    busy_i = 1;
    watch(7);
    chk("R3 no poll while busy", rx_n, 0);
    busy_i = 0;
    watch(20);
    chk("R3 resume from held count", rx_first, 16);
  endtask

  task automatic t_rx_need;
    do_reset(1'b1, 1'b1, 20);
    rx_en_i = 1; rx_cur_own_i = 1; rx_nxt_own_i = 0;
    busy_i = 0;
    watch(25);
    chk("R4 next descriptor unowned", rx_first, 21);
    rx_ring_one_i = 1;
    watch(45);
    chk("R4 single-entry ring skips next", rx_n, 0);
    rx_ring_one_i = 0; rx_en_i = 0; rx_cur_own_i = 0;
    watch(45);
    chk("R5 receive disabled", rx_n, 0);
  endtask

  task automatic t_tx_gate;
    do_reset(1'b1, 1'b1, 20);
    tx_en_i = 1; tx_cur_own_i = 0;
    busy_i = 0;
    watch(25);
    chk("R6 transmit interval poll", tx_first, 21);
    tx_poll_dis_i = 1;
    watch(45);
    chk("R6 polling disabled", tx_n, 0);
    tx_poll_dis_i = 0; tx_en_i = 0;
    watch(45);
    chk("R6 transmit disabled", tx_n, 0);
    tx_en_i = 1; tx_cur_own_i = 1;
    watch(45);
    chk("R6 descriptor owned", tx_n + rx_n, 0);
  endtask

  task automatic t_done;
    do_reset(1'b0, 1'b0, 0);
    rx_en_i = 1; rx_cur_own_i = 0; tx_en_i = 1; tx_cur_own_i = 0;
    busy_i = 0;
    @(negedge clk_i);
    tx_done_i = 1;
    watch(8);
    chk("R7 rx poll after transmit done", rx_first, 2);
    chk("R7 tx poll after transmit done", tx_first, 4);
    chk("R7 one poll each", rx_n + tx_n, 2);
    rx_en_i = 0;
    rx_done_i = 1;
    watch(8);
    chk("R7 tx poll after receive done", tx_first, 2);
  endtask

  task automatic t_demand;
    do_reset(1'b0, 1'b0, 0);
    rx_en_i = 1; rx_cur_own_i = 0; tx_en_i = 1; tx_cur_own_i = 0;
    busy_i = 0;
    @(negedge clk_i);
    tx_demand_i = 1;
    watch(8);
    chk("R8 receive poll first", rx_first, 2);
    chk("R8 transmit poll after", tx_first, 4);
    chk("R8 never together", both_n, 0);
    rx_cur_own_i = 1; rx_nxt_own_i = 1;
    tx_demand_i = 1;
    watch(8);
    chk("R8 transmit at once when rx owned", tx_first, 2);
    chk("R8 no rx poll when owned", rx_n, 0);
  endtask

  task automatic t_outstanding;
    do_reset(1'b1, 1'b1, 20);
    rx_en_i = 1; rx_cur_own_i = 0;
    ack_auto = 0;
    busy_i = 0;
    watch(21);
    chk("R9 first poll", rx_first, 21);
    watch(1);
    chk("R9 single-cycle pulse", int'(rx_poll_o), 0);
    watch(40);
    chk("R9 held until ack", rx_n, 0);
    rx_ack_man = 1;
    watch(5);
    chk("R11 latched elapse polls after ack", rx_first, 2);
    chk("R11 exactly one", rx_n, 1);
    ack_auto = 1;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset_default();
    t_interval();
    t_pause();
    t_rx_need();
    t_tx_gate();
    t_done();
    t_demand();
    t_outstanding();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule